// File: doc/BRIEF.md
# Reduced PCI Target Transaction Controller

This block is the target side of a 32-bit PCI bus interface, cut down to the transactions a memory-mapped peripheral needs. On every address phase it classifies the command on C/BE# and compares the upper address bits with a single base address. It claims only memory reads and memory writes that fall inside that window. The cache-oriented read and write variants run as plain reads and writes. Every other command passes unclaimed, so the bus master ends it with a master abort.

Once it claims a cycle, the controller asserts DEVSEL# with medium decode timing. It then runs zero-wait data phases against a simple local port that carries a word address, write data, byte enables and one-cycle read or write strobes. Burst addresses advance by one word per completed data phase. If the two low address bits of the address phase are not zero, the burst order is not linear. In that case the first data phase completes with STOP# asserted and the controller then backs off, so the master can move only one word. There are no tri-state pins: every driven bus signal comes with an output-enable that the pad ring uses.

Top module: `pcit_target`

## Requirements
- R1: While reset is active and on the first cycle after it, ctl_oe, ad_oe, loc_wr and loc_rd are all 0.
- R2: A memory read (C/BE# 0110) or memory write (0111) is claimed when address bits [31:WIN_BITS] equal bar_base. DEVSEL# is driven low for the first time on the second clock after the address phase and is not driven on the first.
- R3: The controller never drives DEVSEL# for the following commands: interrupt acknowledge (0000), special cycle (0001), I/O read (0010), I/O write (0011), configuration read and write (1010, 1011) and dual address cycle (1101). The same holds for a memory command outside the window. Local memory is left untouched in these cases.
- R4: Memory read multiple (1100) and memory read line (1110) return the same data as a memory read. Memory write and invalidate (1111) stores data exactly as a memory write does.
- R5: When AD[1:0] is 00 at the address phase, the data phases of a burst address consecutive words. The first word is at AD[WIN_BITS-1:2] of the address phase, and loc_addr advances by one after each completed data phase.
- R6: When AD[1:0] is not 00, the first data phase completes with STOP# low. At most one word is transferred, and no further TRDY# follows.
- R7: A data phase completes on a clock where IRDY# and TRDY# are both low. Each completed write phase gives exactly one loc_wr pulse, with loc_be equal to the inverted C/BE# of that phase. Only bytes whose loc_be bit is 1 change.
- R8: On a read, AD is not driven during the clock after the address phase (turnaround). After that, each completed phase carries the local word at the current address.
- R9: After the last data phase, DEVSEL#, TRDY# and STOP# are driven high for exactly one clock with ctl_oe = 1. On the next clock ctl_oe is 0.
- R10: TRDY# is never driven low unless DEVSEL# is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_base | input | 32-WIN_BITS | Base address of the claimed window (upper bits) |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| cbe_n | input | 4 | C/BE#: command in the address phase, byte enables in data phases |
| ad_in | input | 32 | AD bus as received |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Output enable for AD |
| devsel_n_out | output | 1 | DEVSEL# value |
| trdy_n_out | output | 1 | TRDY# value |
| stop_n_out | output | 1 | STOP# value |
| ctl_oe | output | 1 | Output enable shared by DEVSEL#, TRDY# and STOP# |
| loc_addr | output | WIN_BITS-2 | Word address inside the window |
| loc_wdata | output | 32 | Write data to the local port |
| loc_be | output | 4 | Active-high byte enables for writes |
| loc_wr | output | 1 | One-cycle write strobe, one per completed write phase |
| loc_rd | output | 1 | One-cycle read strobe, one per completed read phase |
| loc_rdata | input | 32 | Word returned by the local port for loc_addr |

## Verification
The assertions check the following on every cycle:
- TRDY# is never asserted without DEVSEL#.
- DEVSEL# first falls two clocks after an address phase.
- After a miss, the control lines are not driven.
- The control lines are released one clock after the turn-off cycle.
- AD stays released during the turnaround.
- The word address steps by one.
- An out-of-order burst never transfers a second word.

Other behaviour can only be shown by the bench's transaction scenarios:
- how each command code is classified;
- that the aliased cache commands move the same data as their plain forms;
- that byte enables merge into stored words;
- that ignored commands leave local memory untouched.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

    // Bus command encodings carried on C/BE# during the address phase
    localparam logic [3:0] CMD_MEM_RD       = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR       = 4'b0111;
    localparam logic [3:0] CMD_MEM_RD_MULTI = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WR_INV   = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DATA,
        ST_BACKOFF,
        ST_TURNOFF,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic claim;
        logic write;
        logic nonlin;
    } decode_t;

    // Maps a command plus window hit onto the reduced transaction set
    function automatic decode_t classify(input logic [3:0] cmd,
                                         input logic       hit,
                                         input logic [1:0] order);
        decode_t d;
        d.write  = 1'b0;
        d.claim  = 1'b0;
        d.nonlin = (order != 2'b00);
        case (cmd)
            CMD_MEM_RD, CMD_MEM_RD_MULTI, CMD_MEM_RD_LINE: d.claim = hit;
            CMD_MEM_WR, CMD_MEM_WR_INV: begin
                d.claim = hit;
                d.write = 1'b1;
            end
            default: d.claim = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode #(
    parameter int WIN_BITS = 12
) (
    input  logic [3:0]          cmd_n,
    input  logic [31:WIN_BITS]  addr_hi,
    input  logic [31:WIN_BITS]  base_hi,
    input  logic [1:0]          order,
    output pcit_pkg::decode_t   dec
);
    logic hit;

    always_comb begin
        hit = (addr_hi == base_hi);
        dec = pcit_pkg::classify(cmd_n, hit, order);
    end
endmodule

// File: rtl/pcit_addr_ctr.sv
module pcit_addr_ctr #(
    parameter int WIN_BITS = 12,
    localparam int LW = WIN_BITS - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          adv,
    output logic [LW-1:0] word_addr
);
    always_ff @(posedge clk) begin
        if (rst)
            word_addr <= '0;
        else if (load)
            word_addr <= load_val;
        else if (adv)
            word_addr <= word_addr + 1'b1;
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (word_addr == $past(word_addr) + 1'b1));
endmodule

// File: rtl/pcit_fsm.sv
module pcit_fsm (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    input  pcit_pkg::decode_t      dec,
    output pcit_pkg::tgt_state_e   state,
    output pcit_pkg::decode_t      dec_q,
    output logic                   dp_done,
    output logic                   load
);
    import pcit_pkg::*;

    always_comb begin
        load    = (state == ST_IDLE) && !frame_n && dec.claim;
        dp_done = (state == ST_DATA) && !irdy_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dec_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (!frame_n) begin
                    state <= dec.claim ? ST_DECODE : ST_IGNORE;
                    dec_q <= dec;
                end
                ST_DECODE: state <= ST_DATA;
                ST_DATA: if (dp_done) begin
                    if (frame_n)
                        state <= ST_TURNOFF;
                    else if (dec_q.nonlin)
                        state <= ST_BACKOFF;
                end
                ST_BACKOFF: if (frame_n) state <= ST_TURNOFF;
                ST_TURNOFF: state <= ST_IDLE;
                ST_IGNORE:  if (frame_n && irdy_n) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // R6
    single_word_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_done && dec_q.nonlin) |=> (state != ST_DATA));
endmodule

// File: rtl/pcit_target.sv
module pcit_target #(
    parameter int WIN_BITS = 12,
    localparam int LW = WIN_BITS - 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:WIN_BITS]   bar_base,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic [3:0]           cbe_n,
    input  logic [31:0]          ad_in,
    output logic [31:0]          ad_out,
    output logic                 ad_oe,
    output logic                 devsel_n_out,
    output logic                 trdy_n_out,
    output logic                 stop_n_out,
    output logic                 ctl_oe,
    output logic [LW-1:0]        loc_addr,
    output logic [31:0]          loc_wdata,
    output logic [3:0]           loc_be,
    output logic                 loc_wr,
    output logic                 loc_rd,
    input  logic [31:0]          loc_rdata
);
    import pcit_pkg::*;

    decode_t    dec;
    decode_t    dec_q;
    tgt_state_e state;
    logic       dp_done;
    logic       load;

    pcit_decode #(.WIN_BITS(WIN_BITS)) u_decode (
        .cmd_n   (cbe_n),
        .addr_hi (ad_in[31:WIN_BITS]),
        .base_hi (bar_base),
        .order   (ad_in[1:0]),
        .dec     (dec)
    );

    pcit_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .dec     (dec),
        .state   (state),
        .dec_q   (dec_q),
        .dp_done (dp_done),
        .load    (load)
    );

    pcit_addr_ctr #(.WIN_BITS(WIN_BITS)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (ad_in[WIN_BITS-1:2]),
        .adv       (dp_done),
        .word_addr (loc_addr)
    );

    always_comb begin
        ctl_oe       = (state == ST_DATA) || (state == ST_BACKOFF) || (state == ST_TURNOFF);
        devsel_n_out = !((state == ST_DATA) || (state == ST_BACKOFF));
        trdy_n_out   = (state != ST_DATA);
        stop_n_out   = !(((state == ST_DATA) && dec_q.nonlin) || (state == ST_BACKOFF));
        ad_oe        = (state == ST_DATA) && !dec_q.write;
        ad_out       = loc_rdata;
        loc_wdata    = ad_in;
        loc_be       = ~cbe_n;
        loc_wr       = dp_done && dec_q.write;
        loc_rd       = dp_done && !dec_q.write;
    end

    // R10
    trdy_devsel_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && !trdy_n_out) |-> !devsel_n_out);

    // R2
    devsel_medium_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n_out) |-> ($past(frame_n, 2) == 1'b0));

    // R3
    unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && !frame_n && !dec.claim) |=> !ctl_oe);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && devsel_n_out) |=> !ctl_oe);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> !ad_oe);
endmodule

// File: tb/pcit_target_tb.sv
module pcit_target_tb;
    localparam int WB = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1;
    logic irdy_n = 1'b1;
    logic [3:0] cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic ad_oe, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe;
    logic [WB-3:0] loc_addr;
    logic [31:0] loc_wdata, loc_rdata;
    logic [3:0] loc_be;
    logic loc_wr, loc_rd;

    always #2.5 clk = ~clk;

    pcit_target #(.WIN_BITS(WB)) u_dut (
        .clk(clk), .rst(rst), .bar_base(20'h40000),
        .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n_out(devsel_n_out),
        .trdy_n_out(trdy_n_out), .stop_n_out(stop_n_out), .ctl_oe(ctl_oe),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_be(loc_be),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_rdata(loc_rdata)
    );

    // Local memory model
    logic [31:0] mem [0:15];
    assign loc_rdata = mem[loc_addr[3:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if (loc_wr) begin
            for (int b = 0; b < 4; b++)
                if (loc_be[b]) mem[loc_addr[3:0]][8*b +: 8] <= loc_wdata[8*b +: 8];
        end
    end

    int wr_pulses = 0;
    logic [3:0] last_be = '0;
    always @(posedge clk) if (loc_wr) begin
        wr_pulses <= wr_pulses + 1;
        last_be   <= loc_be;
    end

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [2:0]  n;
        logic [31:0] wbase;
        logic        claim;
        logic [2:0]  words;
        logic        stop;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'h7, 32'h4000_0000, 3'd3, 32'hA000_0000, 1'b1, 3'd3, 1'b0},
        '{4'h6, 32'h4000_0000, 3'd3, 32'h0,         1'b1, 3'd3, 1'b0},
        '{4'hF, 32'h4000_0010, 3'd2, 32'hB000_0000, 1'b1, 3'd2, 1'b0},
        '{4'hE, 32'h4000_0010, 3'd2, 32'h0,         1'b1, 3'd2, 1'b0},
        '{4'hC, 32'h4000_0000, 3'd2, 32'h0,         1'b1, 3'd2, 1'b0},
        '{4'h3, 32'h4000_0020, 3'd1, 32'hDEAD_0000, 1'b0, 3'd0, 1'b0},
        '{4'h6, 32'h4000_0020, 3'd1, 32'h0,         1'b1, 3'd1, 1'b0},
        '{4'h2, 32'h4000_0020, 3'd1, 32'h0,         1'b0, 3'd0, 1'b0},
        '{4'h0, 32'h4000_0020, 3'd1, 32'h0,         1'b0, 3'd0, 1'b0},
        '{4'h1, 32'h4000_0020, 3'd1, 32'h0,         1'b0, 3'd0, 1'b0},
        '{4'hD, 32'h4000_0020, 3'd1, 32'h0,         1'b0, 3'd0, 1'b0},
        '{4'hB, 32'h4000_0020, 3'd1, 32'h5555_0000, 1'b0, 3'd0, 1'b0},
        '{4'h7, 32'h4000_1020, 3'd1, 32'hEEEE_0000, 1'b0, 3'd0, 1'b0},
        '{4'h6, 32'h4000_0020, 3'd1, 32'h0,         1'b1, 3'd1, 1'b0},
        '{4'h7, 32'h4000_0031, 3'd3, 32'hC000_0000, 1'b1, 3'd1, 1'b1},
        '{4'h6, 32'h4000_0030, 3'd2, 32'h0,         1'b1, 3'd2, 1'b0},
        '{4'h6, 32'h4000_0002, 3'd2, 32'h0,         1'b1, 3'd1, 1'b1}
    };

    logic [31:0] shadow [0:15];
    logic [31:0] rd_cap [0:3];
    bit t_claimed, t_stop, t_early, t_turn_ok, t_ended;
    int t_words, t_first_dev;

    task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input logic [31:0] wbase, input logic [3:0] be_n);
        bit xf, sp, last;
        t_claimed = 0; t_stop = 0; t_early = 0; t_turn_ok = 0; t_ended = 0;
        t_words = 0; t_first_dev = -1;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        frame_n = (n == 1); irdy_n = 1'b0; cbe_n = be_n; ad_in = wbase;
        for (int c = 0; c < 8; c++) begin
            #1;
            xf = ctl_oe && !trdy_n_out && !irdy_n;
            sp = ctl_oe && !stop_n_out;
            last = frame_n;
            if (c == 0) t_early = ctl_oe || ad_oe;
            if (ctl_oe && !devsel_n_out) begin
                if (t_first_dev < 0) t_first_dev = c;
                t_claimed = 1;
            end
            if (xf && t_words < 4) begin
                rd_cap[t_words] = ad_out;
                t_words++;
            end
            if (sp) t_stop = 1;
            @(negedge clk);
            if ((xf && last) || (sp && !xf && last)) begin
                t_ended = 1;
                break;
            end
            if (xf) ad_in = wbase + t_words;
            if (sp) frame_n = 1'b1;
            else if (xf && t_words == n - 1) frame_n = 1'b1;
        end
        frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
        if (t_ended) begin
            #1;
            t_turn_ok = ctl_oe && devsel_n_out && trdy_n_out && stop_n_out;
            @(negedge clk);
            #1;
            t_turn_ok = t_turn_ok && !ctl_oe;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int wp0;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!ctl_oe && !ad_oe && !loc_wr && !loc_rd, "R1 outputs idle in reset",
            {28'd0, ctl_oe, ad_oe, loc_wr, loc_rd}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!ctl_oe && !ad_oe && !loc_wr && !loc_rd, "R1 outputs idle after reset",
            {28'd0, ctl_oe, ad_oe, loc_wr, loc_rd}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            vec_t e;
            e = VECS[v];
            wp0 = wr_pulses;
            xfer(e.cmd, e.addr, int'(e.n), e.wbase, 4'h0);
            chk(t_claimed == e.claim, "R2 R3 claim decision", {31'd0, t_claimed}, {31'd0, e.claim});
            chk(t_words == int'(e.words), "R5 R6 words moved", t_words, {29'd0, e.words});
            chk(t_stop == e.stop, "R6 disconnect", {31'd0, t_stop}, {31'd0, e.stop});
            if (e.claim) begin
                chk(t_first_dev == 1 && !t_early, "R2 R8 medium decode and turnaround",
                    t_first_dev, 32'd1);
                chk(t_turn_ok, "R9 one-clock turn-off then release", {31'd0, t_turn_ok}, 32'd1);
                if (e.cmd[0]) begin
                    chk(wr_pulses - wp0 == int'(e.words), "R7 one write strobe per phase",
                        wr_pulses - wp0, {29'd0, e.words});
                    for (int k = 0; k < int'(e.words); k++)
                        shadow[(e.addr[5:2] + k) & 4'hF] = e.wbase + k;
                end else begin
                    for (int k = 0; k < int'(e.words); k++)
                        chk(rd_cap[k] == shadow[(e.addr[5:2] + k) & 4'hF], "R4 R5 R8 read data",
                            rd_cap[k], shadow[(e.addr[5:2] + k) & 4'hF]);
                end
            end else begin
                chk(wr_pulses == wp0, "R3 no local write", wr_pulses - wp0, 32'd0);
            end
        end

        // R7 byte enables: only the low two bytes enabled
        xfer(4'h7, 32'h4000_0008, 1, 32'h1122_3344, 4'b1100);
        chk(last_be == 4'b0011, "R7 loc_be inverted C/BE#", {28'd0, last_be}, 32'h3);
        shadow[2] = {shadow[2][31:16], 16'h3344};
        xfer(4'h6, 32'h4000_0008, 1, 32'h0, 4'h0);
        chk(rd_cap[0] == shadow[2], "R7 partial write merged", rd_cap[0], shadow[2]);

        // R5 long linear burst crossing previously written words
        xfer(4'h7, 32'h4000_0020, 3, 32'h7700_0000, 4'h0);
        for (int k = 0; k < 3; k++) shadow[8 + k] = 32'h7700_0000 + k;
        xfer(4'h6, 32'h4000_001C, 3, 32'h0, 4'h0);
        for (int k = 0; k < 3; k++)
            chk(rd_cap[k] == shadow[7 + k], "R5 incrementing burst", rd_cap[k], shadow[7 + k]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule